// File: doc/BRIEF.md
# Frame Elastic Store with Conditional Re-centre

This block is a two-clock byte buffer that sits between a recovered line clock and a local system clock on a framed serial link. Bytes arrive on the write side at the line rate and leave on the read side at the system rate. Small rate differences between the clocks are absorbed by the gap between the two pointers. The default buffer holds two frames of 32 byte slots, which is 64 bytes. The read side reports the current pointer gap. When the pointers are about to meet in either direction, the read side slips by one whole frame.

A level input gives software a re-centre command. Only a rising edge counts. When the edge is seen, the block compares the gap with half a frame (16 bytes). If the gap is below that, the read pointer is moved to 16 bytes behind the write pointer, even though this disturbs the data already in the buffer. If the gap is already 16 or more, nothing changes. One instance serves each direction of a link, and each instance has its own system clock and its own command input.

Top module: `elastic_store`

## Requirements
- R1: After reset, `fill` reads 16 and both slip outputs are low.
- R2: Without slips or re-centres, bytes leave in the order they were written.
- R3: `fill` equals bytes written minus bytes read, modulo 64. A single write shows up in `fill` within three read-clock cycles.
- R4: A rising edge on `align_req` while `fill` is below 16 sets `fill` to 16. The next byte read is the 16th most recent byte written.
- R5: A rising edge on `align_req` while `fill` is 16 or more has no effect: `fill` is unchanged and the byte order continues.
- R6: Holding `align_req` high causes no further re-centre. Another re-centre needs the input to fall and then rise again.
- R7: A read while `fill` is 0 raises `slip_rep`. The byte returned is the one written 32 positions earlier, and `fill` becomes 31.
- R8: A read while `fill` is 60 or more raises `slip_skip`. The byte returned is 32 positions past the oldest unread byte, and `fill` drops by 33. At `fill` 59 the read is normal.
- R9: Each slip output is high for exactly one read cycle, and the two are never high together.
- R10: The write pointer crosses the clock domains as Gray code. During a write burst, `fill` steps by at most one per read cycle.
- R11: `rd_data` is registered. It updates on the read-clock edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side (write) clock |
| rclk | input | 1 | System-side (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each domain |
| wr_en | input | 1 | Write one byte on this wclk edge |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte on this rclk edge |
| rd_data | output | 8 | Last byte read |
| align_req | input | 1 | Re-centre command level; acts on its rising edge |
| fill | output | 6 | Pointer gap seen in the read domain |
| slip_rep | output | 1 | One-cycle flag: a frame was repeated (buffer ran empty) |
| slip_skip | output | 1 | One-cycle flag: a frame was dropped (buffer ran full) |

## Verification
The bench probes the re-centre threshold on both sides: a gap of exactly 16 must be left alone, and a gap of 15 must be re-centred. A design with an off-by-one comparison would either disturb a healthy stream or miss a needed correction. It also holds the command high across a second drift to check that a level-sensitive design, which would re-centre again, is caught. The empty and full slips are driven right at their thresholds (0, 59, 60), and the returned byte and the remaining gap are checked. A wrong jump direction or size would show up as a wrong byte or a wrong gap. A burst of writes checks that the gap seen in the read domain moves in single steps, and a random mix of reads and writes checks that byte order is kept.

// File: rtl/es_pkg.sv
`timescale 1ns/1ps
package es_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_wide_t;

  typedef struct packed {
    logic rep;
    logic skip;
  } slip_t;

  function automatic ptr_wide_t to_gray(input ptr_wide_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_wide_t from_gray(input ptr_wide_t g);
    ptr_wide_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/es_rst_sync.sv
`timescale 1ns/1ps
module es_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_n_out = stg_q[1];
endmodule

// File: rtl/es_sync.sv
`timescale 1ns/1ps
module es_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/es_dpram.sv
`timescale 1ns/1ps
module es_dpram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata_q <= mem_q[raddr];
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/es_wr_ctrl.sv
`timescale 1ns/1ps
module es_wr_ctrl import es_pkg::*; #(
  parameter int AW   = 6,
  parameter int INIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] wgray
);
  localparam logic [AW-1:0] INIT_BIN  = AW'(INIT);
  localparam logic [AW-1:0] INIT_GRAY = AW'(to_gray(ptr_wide_t'(INIT)));
  localparam logic [AW-1:0] ONE_P     = AW'(1);

  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] gray_q, gray_d;

  always_comb begin
    wptr_d = wptr_q;
    gray_d = gray_q;
    if (wr_en) begin
      wptr_d = wptr_q + ONE_P;
      gray_d = AW'(to_gray(ptr_wide_t'(wptr_d)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= INIT_BIN;
      gray_q <= INIT_GRAY;
    end else if (wr_en) begin
      wptr_q <= wptr_d;
      gray_q <= gray_d;
    end
  end

  assign wptr  = wptr_q;
  assign wgray = gray_q;

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr_q == $past(wptr_q) + ONE_P)); // R2
  AST_WPTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr_q)); // R2
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R10
endmodule

// File: rtl/es_rd_ctrl.sv
`timescale 1ns/1ps
module es_rd_ctrl import es_pkg::*; #(
  parameter int AW      = 6,
  parameter int FRAME   = 32,
  parameter int HALF    = 16,
  parameter int SLIP_HI = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          align_lvl,
  input  logic [AW-1:0] wgray_s,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW-1:0] fill,
  output slip_t         slip
);
  localparam logic [AW-1:0] FRAME_P   = AW'(FRAME);
  localparam logic [AW-1:0] HALF_P    = AW'(HALF);
  localparam logic [AW-1:0] SLIP_HI_P = AW'(SLIP_HI);
  localparam logic [AW-1:0] ONE_P     = AW'(1);

  logic [AW-1:0] rptr_q, rptr_d, rptr_eff;
  logic [AW-1:0] wbin, fill_c;
  logic          align_prev_q, align_pulse, align_do;
  slip_t         slip_q, slip_d;

  // Separation and command edge, all in the read domain
  always_comb begin
    wbin        = AW'(from_gray(ptr_wide_t'(wgray_s)));
    fill_c      = wbin - rptr_q;
    align_pulse = align_lvl & ~align_prev_q;
    align_do    = align_pulse && (fill_c < HALF_P);
  end

  // Next read pointer: re-centre first, then read with optional frame slip
  always_comb begin
    rptr_eff = rptr_q;
    rptr_d   = rptr_q;
    slip_d   = '0;
    mem_re   = 1'b0;
    if (align_do) begin
      rptr_d = wbin - HALF_P;
    end else if (rd_en) begin
      if (fill_c == '0) begin
        rptr_eff   = rptr_q - FRAME_P;
        slip_d.rep = 1'b1;
      end else if (fill_c >= SLIP_HI_P) begin
        rptr_eff    = rptr_q + FRAME_P;
        slip_d.skip = 1'b1;
      end
      mem_re = 1'b1;
      rptr_d = rptr_eff + ONE_P;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q       <= '0;
      slip_q       <= '0;
      align_prev_q <= 1'b0;
    end else begin
      rptr_q       <= rptr_d;
      slip_q       <= slip_d;
      align_prev_q <= align_lvl;
    end
  end

  assign mem_raddr = rptr_eff;
  assign fill      = fill_c;
  assign slip      = slip_q;

  AST_ALIGN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    align_do |=> (fill_c >= HALF_P)); // R4
  AST_ALIGN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (align_pulse && !align_do && !rd_en) |=> (rptr_q == $past(rptr_q))); // R5
  AST_ALIGN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    align_pulse |=> !align_pulse); // R6
  AST_REP_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q.rep |-> (rptr_q == $past(rptr_q) - FRAME_P + ONE_P)); // R7
  AST_SKIP_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q.skip |-> (rptr_q == $past(rptr_q) + FRAME_P + ONE_P)); // R8
  AST_SLIP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(slip_q.rep && slip_q.skip)); // R9
  AST_REP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q.rep |=> !slip_q.rep); // R9
  AST_SKIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q.skip |=> !slip_q.skip); // R9
endmodule

// File: rtl/elastic_store.sv
`timescale 1ns/1ps
module elastic_store import es_pkg::*; #(
  parameter int DW          = 8,
  parameter int SLOTS       = 32,
  parameter int FRAMES      = 2,
  parameter int MARGIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 wclk,
  input  logic                                 rclk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [DW-1:0]                        wr_data,
  input  logic                                 rd_en,
  output logic [DW-1:0]                        rd_data,
  input  logic                                 align_req,
  output logic [$clog2(SLOTS*FRAMES)-1:0]      fill,
  output logic                                 slip_rep,
  output logic                                 slip_skip
);
  localparam int DEPTH   = SLOTS * FRAMES;
  localparam int AW      = $clog2(DEPTH);
  localparam int HALF    = SLOTS / 2;
  localparam int SLIP_HI = DEPTH - MARGIN;
  localparam logic [AW-1:0] INIT_GRAY = AW'(to_gray(ptr_wide_t'(HALF)));

  logic          wrst_n, rrst_n;
  logic [AW-1:0] wptr, wgray, wgray_s;
  logic          align_s;
  logic          mem_re;
  logic [AW-1:0] mem_raddr;
  slip_t         slip;

  es_rst_sync u_wrst (.clk(wclk), .rst_n_in(rst_n), .rst_n_out(wrst_n));
  es_rst_sync u_rrst (.clk(rclk), .rst_n_in(rst_n), .rst_n_out(rrst_n));

  es_wr_ctrl #(.AW(AW), .INIT(HALF)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .wptr(wptr), .wgray(wgray)
  );

  es_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(INIT_GRAY)) u_wsync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  es_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_async (
    .clk(rclk), .rst_n(rrst_n), .d(align_req), .q(align_s)
  );

  es_rd_ctrl #(.AW(AW), .FRAME(SLOTS), .HALF(HALF), .SLIP_HI(SLIP_HI)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .align_lvl(align_s),
    .wgray_s(wgray_s), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .fill(fill), .slip(slip)
  );

  es_dpram #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(wr_en & wrst_n), .waddr(wptr), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
  );

  assign slip_rep  = slip.rep;
  assign slip_skip = slip.skip;
endmodule

// File: tb/test_elastic_store.sv
`timescale 1ns/1ps
module test_elastic_store;
  localparam int FRAME   = 32;
  localparam int HALF    = 16;
  localparam int SLIP_HI = 60;
  localparam int HSZ     = 1024;

  logic       wclk, rclk, rst_n;
  logic       wr_en, rd_en, align_req;
  logic [7:0] wr_data, rd_data;
  logic [5:0] fill;
  logic       slip_rep, slip_skip;

  int         n_run, n_fail;
  int         wr_idx, rd_idx;
  logic [7:0] hist [HSZ];
  bit         done;

  elastic_store i_elastic_store (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .align_req(align_req), .fill(fill),
    .slip_rep(slip_rep), .slip_skip(slip_skip)
  );

  initial begin
    wclk = 1'b0;
    forever #2.5 wclk = ~wclk;
  end
  initial begin
    rclk = 1'b0;
    #1.2;
    forever #2.5 rclk = ~rclk;
  end

  function automatic int exp_fill();
    return wr_idx - rd_idx;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic chk_fill(input string req);
    chk(int'(fill) == exp_fill(), req, int'(fill), exp_fill());
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge wclk);
    wr_en   = 1'b1;
    wr_data = d;
    hist[wr_idx] = d;
    wr_idx++;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req);
    int fm;
    bit e_rep, e_skip;
    logic [7:0] d;
    fm     = exp_fill();
    e_rep  = (fm == 0);
    e_skip = (fm >= SLIP_HI);
    if (e_rep) rd_idx -= FRAME;
    else if (e_skip) rd_idx += FRAME;
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    d = rd_data;
    chk(slip_rep == e_rep, {req, " rep flag"}, int'(slip_rep), int'(e_rep));
    chk(slip_skip == e_skip, {req, " skip flag"}, int'(slip_skip), int'(e_skip));
    if (rd_idx >= HALF) chk(d == hist[rd_idx], {req, " data"}, int'(d), int'(hist[rd_idx]));
    rd_idx++;
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    logic [7:0] held;
    n_run = 0; n_fail = 0; done = 1'b0;
    wr_idx = HALF; rd_idx = 0;
    seed = $urandom(32'd5117);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; align_req = 1'b0; wr_data = '0;
    repeat (10) @(negedge wclk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk_fill("R1 fill after reset");
    chk(!slip_rep && !slip_skip, "R1 slips low", int'({slip_rep, slip_skip}), 0);

    // R5 boundary: gap exactly 16 is left alone
    align_req = 1'b1; settle();
    chk_fill("R5 align at gap 16");
    align_req = 1'b0; settle();

    // R3 latency of a single write
    wr_byte(8'hA5);
    repeat (3) @(negedge rclk);
    chk_fill("R3 write seen within three cycles");

    for (int i = 0; i < 15; i++) wr_byte(8'(8'h30 + i));
    settle();
    chk_fill("R3 fill after 16 writes");
    for (int i = 0; i < 32; i++) rd_check("R2 ordered read");

    // R11 output holds without rd_en
    held = rd_data;
    for (int i = 0; i < 4; i++) wr_byte(8'(8'hC0 + i));
    settle();
    chk(rd_data == held, "R11 rd_data holds", int'(rd_data), int'(held));
    chk_fill("R3 fill after more writes");

    // R2 random mix of reads and writes
    for (int i = 0; i < 400; i++) begin
      int fm;
      fm = exp_fill();
      if (fm < 8) wr_byte(8'($urandom));
      else if (fm > 50) rd_check("R2 random read");
      else if ($urandom_range(1, 0) == 1) wr_byte(8'($urandom));
      else rd_check("R2 random read");
    end
    settle();
    chk_fill("R3 fill after random phase");

    // R4: drain to gap 15, then re-centre
    while (exp_fill() < 20) wr_byte(8'($urandom));
    while (exp_fill() > 15) rd_check("R2 drain");
    settle();
    chk_fill("R4 gap 15 before align");
    align_req = 1'b1; settle();
    rd_idx = wr_idx - HALF;
    chk_fill("R4 gap after align");
    rd_check("R4 first byte after align");

    // R6: level held high, drift low again, no second re-centre
    while (exp_fill() > 5) rd_check("R6 read while held");
    settle();
    chk_fill("R6 no align while held high");
    align_req = 1'b0; settle();
    align_req = 1'b1; settle();
    rd_idx = wr_idx - HALF;
    chk_fill("R6 align after fresh rise");
    align_req = 1'b0; settle();

    // R5: larger gap, command is ignored
    for (int i = 0; i < 10; i++) wr_byte(8'($urandom));
    settle();
    align_req = 1'b1; settle();
    chk_fill("R5 align ignored at gap 26");
    for (int i = 0; i < 3; i++) rd_check("R5 order kept");
    align_req = 1'b0; settle();

    // R7: empty read repeats a frame
    while (exp_fill() > 0) rd_check("R2 drain to empty");
    settle();
    chk_fill("R7 empty before slip");
    rd_check("R7 empty slip");
    @(negedge rclk);
    chk(!slip_rep, "R9 repeat flag one cycle", int'(slip_rep), 0);
    settle();
    chk_fill("R7 fill after repeat");

    // R8: full side, boundary at 59 then slip at 60
    while (exp_fill() < 59) wr_byte(8'($urandom));
    settle();
    chk_fill("R8 gap 59");
    rd_check("R8 no slip at 59");
    wr_byte(8'($urandom)); wr_byte(8'($urandom));
    settle();
    chk_fill("R8 gap 60");
    rd_check("R8 skip slip");
    chk(!(slip_rep && slip_skip), "R9 flags exclusive", int'({slip_rep, slip_skip}), 1);
    @(negedge rclk);
    chk(!slip_skip, "R9 skip flag one cycle", int'(slip_skip), 0);
    settle();
    chk_fill("R8 fill after skip");
    rd_check("R8 order after skip");

    // R10: burst of writes, gap steps by at most one per read cycle
    begin
      int bad;
      int prev;
      bad = 0;
      prev = int'(fill);
      fork
        begin
          @(negedge wclk);
          wr_en = 1'b1;
          for (int i = 0; i < 20; i++) begin
            wr_data = 8'($urandom);
            hist[wr_idx] = wr_data;
            wr_idx++;
            @(negedge wclk);
          end
          wr_en = 1'b0;
        end
        begin
          for (int i = 0; i < 30; i++) begin
            @(negedge rclk);
            if (int'(fill) != prev && int'(fill) != prev + 1) bad++;
            prev = int'(fill);
          end
        end
      join
      chk(bad == 0, "R10 single-step gap during burst", bad, 0);
    end
    settle();
    chk_fill("R10 fill after burst");
    rd_check("R2 read after burst");

    finish_run();
  end
endmodule